// File: doc/BRIEF.md
# Priority Interrupt Level Controller

This block gathers fifteen level-sensitive external request lines and a sixteen-bit software-interrupt word into a single pending vector. It picks the highest pending level and posts a trap code for the processor core. The trap code is a parameterised external-interrupt class base ORed with the level number. A hard-interrupt request stays asserted for as long as a code is posted. A one-cycle notification marks each cycle in which a new, different code is posted. A separate wake pulse tells the core to leave its halted state whenever any external line rises.

The core tells the block when a trap of some other kind is pending, by presenting that trap's code. An external interrupt never replaces a trap outside its own class, so in that case the posted code is frozen. The timer bit of the software word (bit 0) does not act at level 0. It is moved up and counted at level 14. The core acknowledges a taken trap with a clear strobe. Evaluation is registered: each input change shows up on the outputs one clock later.

Top module: `pil_ctrl`

## Requirements
- R1: During and directly after synchronous active-high reset, `trap_code` is 0 and `irq_req`, `irq_new` and `wake` are low.
- R2: External line `irq_in[n]` (n = 1..15) requests level n. Software bit `sw_int[n]` (n = 1..15) requests level n. Software bit `sw_int[0]` (timer) requests level 14.
- R3: Among the requested levels, the highest numbered one wins. Level 0 is never selected.
- R4: A posted external code equals `BASE | level`, with `BASE` = 8'h40 and the level in bits 3:0. It appears on the first rising edge after the inputs that cause it.
- R5: `irq_new` is high for exactly the one cycle in which `trap_code` takes a non-zero value different from its previous value. It stays low while the same code is held.
- R6: Let the current trap be `other_code` when `other_vld` is high, and the stored code otherwise. A new selection is made only when the current trap is zero or its bits above bit 3 equal those of `BASE`. Otherwise `trap_code` holds its value.
- R7: When no level is requested and the current trap is of the external class, `trap_code` returns to 0 on the next edge.
- R8: `wake` pulses for one cycle after any external line goes from 0 to 1. Software bits and falling lines do not cause it.
- R9: `ack` clears `trap_code` to 0 on the next edge and takes precedence over any evaluation in that cycle. A request that is still pending is posted again on the edge after that, with an `irq_new` pulse.
- R10: `irq_req` is high exactly when `trap_code` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 15 | External level lines for levels 15..1 (bit n = level n) |
| sw_int | input | 16 | Software-interrupt word; bit 0 is the timer bit |
| other_vld | input | 1 | A trap of another kind is posted in the core |
| other_code | input | 8 | Code of that other trap |
| ack | input | 1 | Core has taken the trap; clear the posted code |
| irq_req | output | 1 | Hard-interrupt request |
| irq_new | output | 1 | One-cycle pulse when a new, different code is posted |
| trap_code | output | 8 | Posted trap code |
| wake | output | 1 | One-cycle pulse to leave the halted state |

## Verification
Two things can collide in one cycle. An acknowledge can arrive while a line is still pending, and a line can rise while a foreign trap freezes the code. The bench drives `ack` on cycles where the pending vector is non-zero. It expects a zero code next, then the same code re-posted with a fresh `irq_new` pulse. It also raises lines under a non-external `other_code`. There it expects `wake` to pulse while `trap_code` holds, and it expects the held code to be released once `other_vld` drops.

// File: rtl/pil_ctrl.sv
module pil_ctrl #(
  parameter int CW = 8,
  parameter logic [CW-1:0] BASE = 8'h40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [15:1]   irq_in,
  input  logic [15:0]   sw_int,
  input  logic          other_vld,
  input  logic [CW-1:0] other_code,
  input  logic          ack,
  output logic          irq_req,
  output logic          irq_new,
  output logic [CW-1:0] trap_code,
  output logic          wake
);
  localparam logic [CW-1:0] HI_MASK = ~CW'(4'hF);
  localparam int TIMER_LVL = 14;

  logic [15:1]   irq_q;
  logic [CW-1:0] code_q, code_d, cur;
  logic [15:0]   word;
  logic [3:0]    lvl;
  logic          any, ext_cls;

  assign word    = {irq_in, 1'b0} | {sw_int[15:1], 1'b0} | (16'(sw_int[0]) << TIMER_LVL);
  assign any     = |word[15:1];
  assign cur     = other_vld ? other_code : code_q;
  assign ext_cls = (cur & HI_MASK) == BASE;

  always_comb begin
    lvl = '0;
    for (int i = 1; i < 16; i++)
      if (word[i]) lvl = 4'(i);
  end

  always_comb begin
    code_d = code_q;
    if (ack)
      code_d = '0;
    else if (any && (cur == '0 || ext_cls))
      code_d = BASE | CW'(lvl);
    else if (!any && ext_cls)
      code_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= '0;
      code_q  <= '0;
      irq_new <= 1'b0;
      wake    <= 1'b0;
    end else begin
      irq_q   <= irq_in;
      code_q  <= code_d;
      irq_new <= (code_d != code_q) && (code_d != '0);
      wake    <= |(irq_in & ~irq_q);
    end
  end

  assign trap_code = code_q;
  assign irq_req   = |code_q;
endmodule

module pil_ctrl_chk #(
  parameter int CW = 8,
  parameter logic [CW-1:0] BASE = 8'h40
) (
  input logic          clk,
  input logic          rst,
  input logic [15:1]   irq_in,
  input logic          other_vld,
  input logic [CW-1:0] other_code,
  input logic          ack,
  input logic          irq_req,
  input logic          irq_new,
  input logic [CW-1:0] trap_code,
  input logic          wake
);
  localparam logic [CW-1:0] HI_MASK = ~CW'(4'hF);

  p_code_form_r4: assert property (@(posedge clk) disable iff (rst)
    (trap_code != '0) |-> ((trap_code & HI_MASK) == BASE && trap_code[3:0] != 4'd0));

  p_ack_clear_r9: assert property (@(posedge clk) disable iff (rst)
    ack |=> (trap_code == '0 && !irq_req));

  p_new_change_r5: assert property (@(posedge clk) disable iff (rst)
    irq_new |-> (trap_code != '0 && trap_code != $past(trap_code)));

  p_foreign_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (other_vld && (other_code & HI_MASK) != BASE && other_code != '0 && !ack) |=> $stable(trap_code));

  p_wake_src_r8: assert property (@(posedge clk) disable iff (rst)
    wake |-> ($past(irq_in) != '0));
endmodule

bind pil_ctrl pil_ctrl_chk #(.CW(CW), .BASE(BASE)) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .other_vld(other_vld),
  .other_code(other_code), .ack(ack), .irq_req(irq_req), .irq_new(irq_new),
  .trap_code(trap_code), .wake(wake)
);

// File: tb/sim_pil_ctrl.sv
`timescale 1ns/1ps
module sim_pil_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:1] irq_in = '0;
  logic [15:0] sw_int = '0;
  logic        other_vld = 1'b0;
  logic [7:0]  other_code = '0;
  logic        ack = 1'b0;
  logic        irq_req, irq_new, wake;
  logic [7:0]  trap_code;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0]  m_code;
  logic [15:1] m_prev;

  always #2.5 clk = ~clk;

  pil_ctrl u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .sw_int(sw_int),
    .other_vld(other_vld), .other_code(other_code), .ack(ack),
    .irq_req(irq_req), .irq_new(irq_new), .trap_code(trap_code), .wake(wake)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:1] e, input logic [15:0] s, input bit ov,
                      input logic [7:0] oc, input bit a, input string req);
    logic [15:0] w;
    logic [3:0]  lv;
    logic [7:0]  cur, nxt;
    bit cls, enew, ewake;
    irq_in = e; sw_int = s; other_vld = ov; other_code = oc; ack = a;
    // R2: levels from lines and software bits, timer bit on level 14
    w = {e, 1'b0} | {s[15:1], 1'b0};
    if (s[0]) w[14] = 1'b1;
    lv = 0;
    for (int i = 15; i >= 1; i--) if (w[i] && lv == 0) lv = 4'(i);
    cur = ov ? oc : m_code;
    cls = cur[7:4] == 4'h4;
    if (a) nxt = 8'h00;
    else if (w != 0 && (cur == 0 || cls)) nxt = 8'h40 + {4'h0, lv};
    else if (w == 0 && cls) nxt = 8'h00;
    else nxt = m_code;
    enew = (nxt != m_code) && (nxt != 0);
    ewake = |(e & ~m_prev);
    @(negedge clk);
    chk(trap_code == nxt, req, trap_code, nxt);
    chk(irq_req == (nxt != 0), {req, "/R10"}, irq_req, nxt != 0);
    chk(irq_new == enew, {req, "/R5"}, irq_new, enew);
    chk(wake == ewake, {req, "/R8"}, wake, ewake);
    m_code = nxt;
    m_prev = e;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_code = 0; m_prev = 0;
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    chk(trap_code == 0 && !irq_req && !irq_new && !wake, "R1", trap_code, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(trap_code == 0 && !irq_req && !irq_new && !wake, "R1", trap_code, 0);

    // R3 R4: every external pattern, highest line wins
    for (int p = 1; p < 32768; p++) step(15'(p), 16'h0, 0, 8'h0, 0, "R3");
    step('0, 16'h0, 0, 8'h0, 0, "R7");
    // R2: every software word, timer bit folded to 14
    for (int p = 0; p < 65536; p++) step('0, 16'(p), 0, 8'h0, 0, "R2");
    step('0, 16'h0001, 0, 8'h0, 0, "R2");
    step('0, 16'h0000, 0, 8'h0, 0, "R7");

    // R6: foreign trap freezes the code, wake still pulses
    step(15'h0004, 16'h0, 0, 8'h0, 0, "R4");
    step(15'h4004, 16'h0, 1, 8'h21, 0, "R6");
    step(15'h0000, 16'h0, 1, 8'h21, 0, "R6");
    step(15'h0000, 16'h0, 1, 8'h45, 0, "R7");
    step(15'h0100, 16'h0, 1, 8'h45, 0, "R6");
    step(15'h0100, 16'h0, 1, 8'h80, 0, "R6");
    step(15'h4100, 16'h0, 0, 8'h0, 0, "R6");

    // R9: ack against a still-pending request
    step(15'h4100, 16'h0, 0, 8'h0, 1, "R9");
    step(15'h4100, 16'h0, 0, 8'h0, 0, "R9");
    step(15'h4100, 16'h0, 0, 8'h0, 0, "R5");
    step(15'h0000, 16'h0, 0, 8'h0, 1, "R9");
    step(15'h0000, 16'h0, 0, 8'h0, 0, "R7");

    // R8: rise, hold, fall; software bits give no wake
    step(15'h0001, 16'h0, 0, 8'h0, 0, "R8");
    step(15'h0001, 16'h0, 0, 8'h0, 0, "R8");
    step(15'h0000, 16'h8000, 0, 8'h0, 0, "R8");
    step(15'h0000, 16'h0000, 0, 8'h0, 0, "R7");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule